// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether an incoming CAN frame is kept. It compares the frame's identifier bytes, bit by bit, against programmable code bytes. A mask byte for each code byte selects which bits take part in the comparison. Eight code bytes and eight mask bytes are held in two banks of four. A mode bit groups them either as two filters over all four identifier bytes, or as four filters over the first two identifier bytes only.

Software programs the filters through a simple byte-wide register port. Reads are always allowed. Writes land only while the controller sits in initialization, which means both the initialization request and the initialization acknowledge are high.

Identifiers enter on a valid/ready stream. `id_ready` is held high, so the block never applies back-pressure and takes an identifier in every cycle that `id_valid` is high. The verdict comes out one clock later on plain status pins that carry no ready.

Top module: `can_id_filter`

## Requirements
- R1: After reset, every code byte, every mask byte and the mode register read back 0, and `res_valid` is 0.
- R2: A register write, including one to the mode register, changes state only when `init_req` and `init_ack` are both 1. In all other cases the write is dropped, and the previous value still reads back.
- R3: `reg_rdata` shows the addressed register in the same cycle, at any time. The address map is:
  - 0–7: code bytes 0–7.
  - 8–15: mask bytes 0–7.
  - 16: mode, with bit 0 meaning 1 = 16-bit mode and 0 = 32-bit mode; the other bits read 0.
  - Any other address reads 0 and ignores writes.
- R4: A mask bit of 0 requires the identifier bit to equal the code bit. A mask bit of 1 removes that bit from the comparison. A filter hits only when every unmasked bit agrees.
- R5: In 32-bit mode, filter 0 compares code/mask bytes 0–3 with identifier bytes 0–3, and filter 1 compares bytes 4–7 with identifier bytes 0–3. Identifier byte k travels on `id_data[8k+7:8k]`.
- R6: In 16-bit mode, filter f (0–3) compares code/mask bytes 2f and 2f+1 with identifier bytes 0 and 1. Identifier bytes 2 and 3 have no effect.
- R7: `accept` is 1 when any active filter hits. `hit_idx` gives the lowest-numbered hitting filter, and reads 0 when nothing hits.
- R8: An identifier taken while `id_valid` is high produces `res_valid` = 1 together with its `accept` and `hit_idx` exactly one clock later. `res_valid` is 0 in the cycle after any cycle with `id_valid` low. `id_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Initialization requested |
| init_ack | input | 1 | Initialization acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| id_valid | input | 1 | Identifier valid |
| id_ready | output | 1 | Always 1 |
| id_data | input | 32 | Identifier bytes 0–3 |
| res_valid | output | 1 | Verdict valid |
| accept | output | 1 | Frame accepted |
| hit_idx | output | 2 | Lowest hitting filter |

## Verification
The hardest state to reach from the ports is a blocked write, because such a write leaves nothing to observe at the outputs. The bench exposes it in two ways. It reads back the code byte it tried to overwrite. It also tries to flip the mode bit while only one of the two initialization signals is high, then sends an all-zero identifier whose verdict differs between the two modes. A second difficult case is two filters hitting at once. The bench handles it with a fully masked filter 3 in 16-bit mode, which hits on every identifier, so the priority encoder has to choose the lower index whenever an earlier filter also hits.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int BYTE_W    = 8;
  localparam int BANK_B    = 4;
  localparam int N_BANK    = 2;
  localparam int REG_BYTES = BANK_B * N_BANK;
  localparam int ADDR_W    = 5;
  localparam int ID_BYTES  = BANK_B;
  localparam int NF16      = REG_BYTES / 2;
  localparam int IDX_W     = $clog2(NF16);
  typedef enum logic [1:0] {REG_CODE = 2'd0, REG_MASK = 2'd1, REG_MODE = 2'd2} reg_region_e;
endpackage

// File: rtl/filt_regs.sv
module filt_regs
  import can_filt_pkg::*;
#(
  parameter int NB = REG_BYTES,
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_open,
  input  logic [AW-1:0]  addr,
  input  logic [BW-1:0]  wdata,
  output logic [BW-1:0]  rdata,
  output logic [NB*BW-1:0] code_flat,
  output logic [NB*BW-1:0] mask_flat,
  output logic           mode16
);
  localparam int SEL_W = $clog2(NB);
  logic [BW-1:0] code_q [NB];
  logic [BW-1:0] mask_q [NB];
  logic          mode_q;
  logic [SEL_W-1:0] sel;
  reg_region_e      region;

  assign sel    = addr[SEL_W-1:0];
  assign region = reg_region_e'(addr[AW-1:SEL_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        code_q[i] <= '0;
        mask_q[i] <= '0;
      end
      mode_q <= 1'b0;
    end else if (wr_en && wr_open) begin
      case (region)
        REG_CODE: code_q[sel] <= wdata;
        REG_MASK: mask_q[sel] <= wdata;
        REG_MODE: if (sel == '0) mode_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (region)
      REG_CODE: rdata = code_q[sel];
      REG_MASK: rdata = mask_q[sel];
      REG_MODE: if (sel == '0) rdata = {{(BW-1){1'b0}}, mode_q};
      default: rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign code_flat[g*BW +: BW] = code_q[g];
    assign mask_flat[g*BW +: BW] = mask_q[g];
  end
  assign mode16 = mode_q;
endmodule

// File: rtl/filt_match.sv
module filt_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] code,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] id,
  output logic         hit
);
  logic [W-1:0] diff;
  assign diff = (code ^ id) & ~mask;
  assign hit  = (diff == '0);
endmodule

// File: rtl/hit_prio.sv
module hit_prio #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end
  assign any = |hits;
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int BW  = BYTE_W,
  parameter int BB  = BANK_B,
  parameter int NBK = N_BANK,
  parameter int AW  = ADDR_W,
  localparam int NB   = BB * NBK,
  localparam int IDW  = BB * BW,
  localparam int HW   = IDW / 2,
  localparam int NF   = NB / 2,
  localparam int IXW  = $clog2(NF)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_req,
  input  logic           init_ack,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [BW-1:0]  reg_wdata,
  output logic [BW-1:0]  reg_rdata,
  input  logic           id_valid,
  output logic           id_ready,
  input  logic [IDW-1:0] id_data,
  output logic           res_valid,
  output logic           accept,
  output logic [IXW-1:0] hit_idx
);
  logic [NB*BW-1:0] code_all, mask_all;
  logic             mode16;
  logic [NF-1:0]    hit16, hits;
  logic [NBK-1:0]   hit32;
  logic             any_hit;
  logic [IXW-1:0]   first_idx;

  filt_regs #(.NB(NB), .BW(BW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_open(init_req & init_ack),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .code_flat(code_all), .mask_flat(mask_all), .mode16(mode16)
  );

  for (genvar b = 0; b < NBK; b++) begin : g_wide
    filt_match #(.W(IDW)) u_m (
      .code(code_all[b*IDW +: IDW]), .mask(mask_all[b*IDW +: IDW]),
      .id(id_data), .hit(hit32[b])
    );
  end

  for (genvar f = 0; f < NF; f++) begin : g_half
    filt_match #(.W(HW)) u_m (
      .code(code_all[f*HW +: HW]), .mask(mask_all[f*HW +: HW]),
      .id(id_data[HW-1:0]), .hit(hit16[f])
    );
  end

  assign hits = mode16 ? hit16 : {{(NF-NBK){1'b0}}, hit32};

  hit_prio #(.N(NF), .IW(IXW)) u_prio (.hits(hits), .any(any_hit), .idx(first_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      accept    <= 1'b0;
      hit_idx   <= '0;
    end else begin
      res_valid <= id_valid;
      if (id_valid) begin
        accept  <= any_hit;
        hit_idx <= any_hit ? first_idx : '0;
      end
    end
  end

  assign id_ready = 1'b1;
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int W = 64,
  parameter int IXW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           init_req,
  input logic           init_ack,
  input logic           id_valid,
  input logic           res_valid,
  input logic           accept,
  input logic [IXW-1:0] hit_idx,
  input logic [W-1:0]   code_all,
  input logic [W-1:0]   mask_all,
  input logic           mode16
);
  AST_RES_AFTER_ID: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> res_valid); // R8
  AST_NO_STRAY_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !res_valid); // R8
  AST_IDX_ZERO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !accept) |-> (hit_idx == '0)); // R7
  AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_req && init_ack) |=> ($stable(code_all) && $stable(mask_all) && $stable(mode16))); // R2
  AST_WIDE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !mode16) |=> (hit_idx < 2)); // R5
endmodule

bind can_id_filter can_id_filter_chk #(.W(NB*BW), .IXW(IXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
  .id_valid(id_valid), .res_valid(res_valid), .accept(accept), .hit_idx(hit_idx),
  .code_all(code_all), .mask_all(mask_all), .mode16(mode16)
);

// File: tb/tb_can_id_filter.sv
module tb_can_id_filter;
  logic clk = 0, rst_n = 0;
  logic init_req = 0, init_ack = 0, reg_wr = 0, id_valid = 0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [31:0] id_data = '0;
  logic id_ready, res_valid, accept;
  logic [1:0] hit_idx;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_id_filter dut (.*);

  // {mode16, id bytes 3..0, accept, idx}
  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 32'h78563412, 1'b1, 2'd0},
    {1'b0, 32'h78563712, 1'b1, 2'd0},
    {1'b0, 32'h78563812, 1'b0, 2'd0},
    {1'b0, 32'h0000CDA5, 1'b1, 2'd1},
    {1'b0, 32'h79563412, 1'b0, 2'd0},
    {1'b1, 32'h00003412, 1'b1, 2'd0},
    {1'b1, 32'hFFFF7856, 1'b1, 2'd1},
    {1'b1, 32'h3412CDA0, 1'b1, 2'd2},
    {1'b1, 32'h00000000, 1'b1, 2'd3},
    {1'b1, 32'h78563412, 1'b1, 2'd0}
  };
  localparam logic [7:0] CODE [8] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'hAB, 8'hCD, 8'hEF, 8'h01};
  localparam logic [7:0] MASK [8] = '{8'h00, 8'h07, 8'h00, 8'h00, 8'h0F, 8'h00, 8'hFF, 8'hFF};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // returns {res_valid, accept, idx} sampled one clock after the strobe
  task automatic send(logic [31:0] id, output logic [3:0] r);
    @(negedge clk); id_valid = 1; id_data = id;
    @(negedge clk); id_valid = 0; r = {res_valid, accept, hit_idx};
  endtask

  initial begin
    logic [7:0] d;
    logic [3:0] r;
    logic [7:0] acc;
    repeat (3) @(negedge clk);
    check("R1 res_valid", {31'b0, res_valid}, 0);
    rst_n = 1;
    acc = 0;
    for (int i = 0; i < 17; i++) begin rd(5'(i), d); acc |= d; end
    check("R1 regs zero", {24'b0, acc}, 0);
    check("R8 ready", {31'b0, id_ready}, 1);
    send(32'h0, r);  check("R4 reset exact zero", {28'b0, r}, 4'b1100);
    send(32'h100, r); check("R4 reset one bit off", {28'b0, r}, 4'b1000);
    @(negedge clk); check("R8 idle", {31'b0, res_valid}, 0);
    wr(5'd0, 8'hEE); rd(5'd0, d); check("R2 no init", {24'b0, d}, 0);
    init_req = 1; init_ack = 1;
    for (int i = 0; i < 8; i++) begin wr(5'(i), CODE[i]); wr(5'(8 + i), MASK[i]); end
    rd(5'd5, d);  check("R3 code5", {24'b0, d}, 32'hCD);
    rd(5'd12, d); check("R3 mask4", {24'b0, d}, 32'h0F);
    wr(5'd31, 8'h5A); rd(5'd31, d); check("R3 unmapped", {24'b0, d}, 0);
    wr(5'd16, 8'hFE); rd(5'd16, d); check("R3 mode bits", {24'b0, d}, 0);
    for (int v = 0; v < NV; v++) begin
      wr(5'd16, {7'b0, VEC[v][35]});
      send(VEC[v][34:3], r);
      check(VEC[v][35] ? "R6/R7 vec" : "R5/R7 vec", {28'b0, r}, {28'b0, 1'b1, VEC[v][2:0]});
    end
    wr(5'd16, 8'h00);
    init_ack = 0;
    wr(5'd16, 8'h01); wr(5'd0, 8'hFF);
    rd(5'd0, d); check("R2 ack low code", {24'b0, d}, 32'h12);
    send(32'h0, r); check("R2 mode held", {28'b0, r}, 4'b1000);
    init_req = 0; init_ack = 1;
    wr(5'd16, 8'h01);
    send(32'h0, r); check("R2 req low mode", {28'b0, r}, 4'b1000);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule